// File: doc/BRIEF.md
# Serial Receive Engine with Mid-Bit Start Validation

This block turns an asynchronous serial line into characters. It runs from a system clock and a one-cycle sample enable that pulses sixteen times per bit period. The line first passes through a short synchronizer. A low line seen at a sample tick while the engine is idle counts as a candidate start edge. Half a bit later the line is checked again. If it has gone back high, the candidate is dropped as a false start and nothing is produced. Otherwise every data bit, the optional parity bit and the stop bit is sampled at its centre, sixteen ticks apart, and the bits shift into an 8-bit register, least significant bit first.

When the stop bit has been sampled, the engine presents the character on a one-cycle valid pulse together with three per-character tags: parity error, framing error and break. The data and tags then hold until the next character. A zero stop bit sends the engine into a recovery wait, and it looks for a new start edge only after it has seen the line high again. The word length (5 to 8 bits), parity enable and parity sense are captured at each start edge. Buffering of characters and any host access sit outside this block.

Top module: `srx_engine`

## Requirements
- R1: After reset, rx_valid, rx_data, rx_perr, rx_ferr and rx_brk are 0. A line that is low at reset produces no character until it has been seen high at a sample tick.
- R2: While idle, a sample tick that sees the synchronized line low starts a character. The line is checked again at the 8th following tick (half a bit), and the start is accepted only if the line is still low there. The line reaches the engine through SYNC_STAGES flops, 2 by default.
- R3: Data bits are sampled every 16 ticks after the accepted mid-start point, least significant bit first. wlen_sel 2'b00, 2'b01, 2'b10 and 2'b11 select 5, 6, 7 and 8 data bits. rx_data holds the received bits right-aligned in rx_data[n-1:0], and the bits above them are 0.
- R4: If the line is high at the mid-start check, no character is produced and the engine returns to idle, ready for the next edge.
- R5: With par_en=1, one parity bit follows the data. par_odd=0 selects even parity and par_odd=1 selects odd parity. rx_perr=1 when the received parity bit does not match. With par_en=0, rx_perr is always 0.
- R6: rx_valid is high for exactly one clock, set by the edge whose tick samples the stop bit. That tick comes 8+16*(n+p+1) ticks after the detecting tick, where n is the number of data bits and p is 1 with parity and 0 without. rx_data and the three flags keep their values until the next pulse.
- R7: rx_ferr=1 when the stop bit is sampled as 0.
- R8: rx_brk=1 when all data bits, the parity bit (if enabled) and the stop bit are 0. A 0 data word with a parity bit of 1 does not set rx_brk.
- R9: After a stop bit sampled as 0, no new start is detected until the line has been seen high at a sample tick. A line that stays low yields exactly one character.
- R10: wlen_sel, par_en and par_odd are captured at the detecting tick. Changing them during a character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle tick, 16 per bit period |
| rxd | input | 1 | Asynchronous serial input, idle high |
| wlen_sel | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid | output | 1 | One-cycle pulse: a character is complete |
| rx_data | output | 8 | Received character, right-aligned |
| rx_perr | output | 1 | Parity mismatch for this character |
| rx_ferr | output | 1 | Stop bit was sampled as 0 |
| rx_brk | output | 1 | Whole frame, stop bit included, was 0 |

## Verification
Assertions check on every cycle that:
- the valid pulse lasts a single clock;
- a rejected start leads straight back to idle;
- the recovery wait holds until a high line is seen at a tick;
- the captured configuration stays frozen while a character is in flight;
- the data bit index stays inside the selected word length;
- the half-bit window never overruns;
- a break always carries a framing error and a zero word.

Only the bench scenarios can show that the right bits land in the right positions for each word length and parity sense, and that the valid pulse arrives on the computed clock. They also show that a short low glitch produces nothing, and that a long low line yields exactly one character before the line recovers.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned SRX_DW = 8;

  typedef enum logic [2:0] {
    ST_RECOVER = 3'd0,
    ST_IDLE    = 3'd1,
    ST_START   = 3'd2,
    ST_DATA    = 3'd3,
    ST_PAR     = 3'd4,
    ST_STOP    = 3'd5
  } srx_state_e;

  // number of data bits for a 2-bit length code
  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // bits arrive at the top of the shift register; move them down to bit 0
  function automatic logic [SRX_DW-1:0] align_word(input logic [SRX_DW-1:0] sr,
                                                   input logic [1:0]        sel);
    int unsigned sh;
    sh = SRX_DW - int'(word_bits(sel));
    return sr >> sh;
  endfunction

  // 1 when data plus parity bit do not give the requested sense
  function automatic logic parity_bad(input logic [SRX_DW-1:0] data,
                                      input logic              pbit,
                                      input logic              odd);
    return (^data) ^ pbit ^ odd;
  endfunction

  // whole frame low: data, parity (if present) and stop
  function automatic logic break_seen(input logic [SRX_DW-1:0] data,
                                      input logic              pe,
                                      input logic              pbit,
                                      input logic              stopb);
    return (data == '0) && !stopb && !(pe && pbit);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic active,
  input  logic half_sel,
  output logic sample_pt
);

  localparam int unsigned HALF = OVS / 2;
  localparam int unsigned CW   = $clog2(OVS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit     = half_sel ? CW'(HALF - 1) : CW'(OVS - 1);
  assign sample_pt = active && tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (active && tick) cnt <= sample_pt ? '0 : cnt + CW'(1);
  end

  // R2: during the start-bit window the count never passes the half-bit point
  a_r2_half_window: assert property (@(posedge clk) disable iff (!rst_n)
    (active && half_sel) |-> (cnt <= CW'(HALF - 1)));

endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sample_pt,
  output logic              timer_restart,
  output logic              timer_active,
  output logic              timer_half,
  output logic              rx_valid,
  output logic [SRX_DW-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk
);

  localparam int unsigned IW = $clog2(SRX_DW) + 1;

  srx_state_e state, state_nx;

  logic [1:0]        cfg_sel;
  logic              cfg_pe;
  logic              cfg_odd;
  logic [SRX_DW-1:0] shreg;
  logic [IW-1:0]     bit_idx;
  logic              par_bit;

  // named internal events
  logic start_det, start_ok, false_start, data_smp, last_data;
  logic par_smp, stop_done, line_back, busy;
  logic [SRX_DW-1:0] word_now;

  assign start_det   = (state == ST_IDLE) && tick && !line;
  assign start_ok    = (state == ST_START) && sample_pt && !line;
  assign false_start = (state == ST_START) && sample_pt && line;
  assign data_smp    = (state == ST_DATA) && sample_pt;
  assign last_data   = (4'(bit_idx) == (word_bits(cfg_sel) - 4'd1));
  assign par_smp     = (state == ST_PAR) && sample_pt;
  assign stop_done   = (state == ST_STOP) && sample_pt;
  assign line_back   = (state == ST_RECOVER) && tick && line;
  assign busy        = (state == ST_START) || (state == ST_DATA) ||
                       (state == ST_PAR)   || (state == ST_STOP);
  assign word_now    = align_word(shreg, cfg_sel);

  assign timer_restart = start_det;
  assign timer_active  = busy;
  assign timer_half    = (state == ST_START);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RECOVER: if (line_back) state_nx = ST_IDLE;
      ST_IDLE:    if (start_det) state_nx = ST_START;
      ST_START: begin
        if (false_start)   state_nx = ST_IDLE;
        else if (start_ok) state_nx = ST_DATA;
      end
      ST_DATA:    if (data_smp && last_data) state_nx = cfg_pe ? ST_PAR : ST_STOP;
      ST_PAR:     if (par_smp) state_nx = ST_STOP;
      ST_STOP:    if (stop_done) state_nx = line ? ST_IDLE : ST_RECOVER;
      default:    state_nx = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RECOVER;
      cfg_sel <= '0;
      cfg_pe  <= 1'b0;
      cfg_odd <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      par_bit <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_det) begin
        cfg_sel <= wlen_sel;
        cfg_pe  <= par_en;
        cfg_odd <= par_odd;
        shreg   <= '0;
        bit_idx <= '0;
        par_bit <= 1'b0;
      end
      if (data_smp) begin
        shreg   <= {line, shreg[SRX_DW-1:1]};
        bit_idx <= bit_idx + IW'(1);
      end
      if (par_smp) par_bit <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_brk   <= 1'b0;
    end else begin
      rx_valid <= stop_done;
      if (stop_done) begin
        rx_data <= word_now;
        rx_ferr <= !line;
        rx_perr <= cfg_pe && parity_bad(word_now, par_bit, cfg_odd);
        rx_brk  <= break_seen(word_now, cfg_pe, par_bit, line);
      end
    end
  end

  // R6: a character is announced for a single clock only
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: a rejected start goes back to idle and announces nothing
  a_r4_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> ((state == ST_IDLE) && !rx_valid));

  // R9: the recovery wait holds until a high line is seen at a tick
  a_r9_recover_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RECOVER) && !(tick && line)) |=> (state == ST_RECOVER));

  // R8: a break always comes with a framing error and a zero word
  a_r8_break_implies_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_ferr && (rx_data == '0)));

  // R5: no parity error without a parity bit
  a_r5_no_perr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_pe) |-> !rx_perr);

  // R3: the data bit index stays inside the selected word length
  a_r3_bit_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (4'(bit_idx) < word_bits(cfg_sel)));

  // R10: the captured configuration is frozen while a character is in flight
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({cfg_sel, cfg_pe, cfg_odd}));

endmodule

// File: rtl/srx_engine.sv
module srx_engine
  import srx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              rxd,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              rx_valid,
  output logic [SRX_DW-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk
);

  logic line_s;
  logic t_restart, t_active, t_half, t_sample;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  srx_bit_timer #(.OVS(OVS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sample_en),
    .restart  (t_restart),
    .active   (t_active),
    .half_sel (t_half),
    .sample_pt(t_sample)
  );

  srx_frame_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (sample_en),
    .line         (line_s),
    .wlen_sel     (wlen_sel),
    .par_en       (par_en),
    .par_odd      (par_odd),
    .sample_pt    (t_sample),
    .timer_restart(t_restart),
    .timer_active (t_active),
    .timer_half   (t_half),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_perr      (rx_perr),
    .rx_ferr      (rx_ferr),
    .rx_brk       (rx_brk)
  );

endmodule

// File: tb/srx_engine_tb.sv
module srx_engine_tb;

  localparam int TDIV = 4;   // clocks per sample tick
  localparam int OVS  = 16;  // ticks per bit
  localparam int BITC = TDIV * OVS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_en;
  logic       rxd;
  logic [1:0] wlen_sel;
  logic       par_en;
  logic       par_odd;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_perr;
  logic       rx_ferr;
  logic       rx_brk;

  always #2 clk = ~clk;

  srx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_odd(par_odd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk)
  );

  typedef struct {
    int         at;
    logic [7:0] d;
    logic       pe;
    logic       fe;
    logic       bk;
  } exp_t;

  exp_t       q[$];
  int         cyc = 0;
  int         nchk = 0;
  int         nfail = 0;
  bit         mon_on = 1'b0;
  logic [7:0] last_d = 8'h00;
  string      phase = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  initial sample_en = 1'b0;
  always @(negedge clk) sample_en <= (((cyc + 1) % TDIV) == 0);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // reference model: expected events, compared on every clock
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0 && q[0].at == cyc) begin
        chk(rx_valid == 1'b1, "R2/R6 valid pulse timing", 32'(rx_valid), 1);
        chk(rx_data == q[0].d, "R3 data bits", 32'(rx_data), 32'(q[0].d));
        chk(rx_perr == q[0].pe, "R5 parity flag", 32'(rx_perr), 32'(q[0].pe));
        chk(rx_ferr == q[0].fe, "R7 framing flag", 32'(rx_ferr), 32'(q[0].fe));
        chk(rx_brk == q[0].bk, "R8 break flag", 32'(rx_brk), 32'(q[0].bk));
        last_d = q[0].d;
        void'(q.pop_front());
      end else begin
        chk(rx_valid == 1'b0, {phase, " no character expected"}, 32'(rx_valid), 0);
        chk(rx_data == last_d, "R6 data held between pulses", 32'(rx_data), 32'(last_d));
      end
    end
  end

  task automatic align_tick();
    @(negedge clk);
    while ((cyc % TDIV) != 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    rxd = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // send one character; the line stays at the stop value afterwards
  task automatic send_char(input logic [7:0] d, input int n, input bit pe, input bit podd,
                           input bit bad_par, input bit stop_v, input bit scramble);
    int         p;
    int         m;
    logic [7:0] dm;
    logic       pb;
    exp_t       e;
    dm = d & 8'((1 << n) - 1);
    pb = (^dm) ^ podd ^ bad_par;
    m  = n + (pe ? 1 : 0) + 1;
    align_tick();
    wlen_sel = 2'(n - 5);
    par_en   = pe;
    par_odd  = podd;
    p = cyc;
    e.at = p + TDIV + TDIV * (OVS / 2 + OVS * m);
    e.d  = dm;
    e.pe = pe && bad_par;
    e.fe = !stop_v;
    e.bk = (dm == 8'h00) && !stop_v && !(pe && pb);
    q.push_back(e);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    if (scramble) begin
      wlen_sel = ~wlen_sel;
      par_en   = ~par_en;
      par_odd  = ~par_odd;
    end
    for (int i = 0; i < n; i++) begin
      rxd = dm[i];
      repeat (BITC) @(negedge clk);
    end
    if (pe) begin
      rxd = pb;
      repeat (BITC) @(negedge clk);
    end
    rxd = stop_v;
    repeat (BITC) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    rxd = 1'b0;
    wlen_sel = 2'b11;
    par_en = 1'b0;
    par_odd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rx_valid == 1'b0, "R1 reset valid", 32'(rx_valid), 0);
    chk(rx_data == 8'h00, "R1 reset data", 32'(rx_data), 0);
    chk({rx_perr, rx_ferr, rx_brk} == 3'b000, "R1 reset flags", 32'({rx_perr, rx_ferr, rx_brk}), 0);
    mon_on = 1'b1;
    // R1: line low out of reset gives nothing
    phase = "R1";
    repeat (300) @(negedge clk);
    idle(100);

    // R3: each word length, no parity
    phase = "R3";
    send_char(8'hA5, 8, 0, 0, 0, 1, 0);
    send_char(8'h15, 5, 0, 0, 0, 1, 0);
    send_char(8'h2A, 6, 0, 0, 0, 1, 0);
    send_char(8'h5B, 7, 0, 0, 0, 1, 0);
    send_char(8'hFF, 5, 0, 0, 0, 1, 0);
    idle(40);

    // R5: parity senses, good and bad
    phase = "R5";
    send_char(8'h3C, 8, 1, 0, 0, 1, 0);
    send_char(8'h3D, 8, 1, 1, 0, 1, 0);
    send_char(8'h6E, 7, 1, 0, 1, 1, 0);
    send_char(8'h13, 5, 1, 1, 1, 1, 0);
    idle(40);

    // R4: short low glitch is rejected
    phase = "R4";
    align_tick();
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    idle(300);
    send_char(8'hC3, 8, 0, 0, 0, 1, 0);
    idle(20);

    // R7 and R9: zero stop bit, line stays low, then recovers
    phase = "R9";
    send_char(8'h81, 8, 0, 0, 0, 0, 0);
    repeat (400) @(negedge clk);
    idle(100);
    send_char(8'h42, 8, 0, 0, 0, 1, 0);
    idle(20);

    // R8: break with even parity, break without parity, zero word with a parity bit of 1
    phase = "R8";
    send_char(8'h00, 8, 1, 0, 0, 0, 0);
    repeat (600) @(negedge clk);
    idle(100);
    send_char(8'h00, 6, 0, 0, 0, 0, 0);
    repeat (200) @(negedge clk);
    idle(100);
    send_char(8'h00, 8, 1, 1, 0, 0, 0);
    repeat (100) @(negedge clk);
    idle(100);

    // R10: configuration changed mid-character
    phase = "R10";
    send_char(8'h2D, 6, 1, 1, 0, 1, 1);
    send_char(8'h96, 8, 0, 0, 0, 1, 1);
    idle(200);

    mon_on = 1'b0;
    chk(q.size() == 0, "R6 all expected characters seen", 32'(q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule